// File: doc/BRIEF.md
# Reorder Buffer with Deferred Fault Reporting

This block keeps in-flight operations in program order while they execute out of order. Each operation claims a slot at issue time and gets back a tag. Execution units later report on that tag with a result, a fault indication and, when known, the resolved value of the guarding predicate. The predicate can also arrive on its own through a separate resolve port, either before or after the completion.

A fault seen during execution is only noted in the slot. It is acted on when the slot reaches the oldest position. At that point the predicate and the noted fault together choose one of three outcomes:

- **Commit:** the predicate is true and there is no fault, so the result is written to the register file.
- **Trap:** the predicate is true and the fault is set. A precise exception is raised on the slot's tag and every slot is cleared.
- **Drop:** the predicate is false. The slot is discarded quietly, together with its result and its fault.

Allocation is a valid/ready stream. A request is taken in any cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_tag` is valid whenever `alloc_ready` is high. `alloc_ready` goes low when all slots are held, and also in a cycle that raises an exception. A request that is held while `alloc_ready` is low has no effect until ready returns. Completion, predicate resolve and the retire outputs are plain strobes with no back-pressure.

Top module: `deferred_fault_rob`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1 and `alloc_tag` is 0. Each accepted allocation is given the tag shown on `alloc_tag`, and the next tag is that value plus one modulo DEPTH (16 by default).
- R2: While DEPTH slots are held, `alloc_ready` is 0, `alloc_valid` has no effect and `alloc_tag` does not move.
- R3: The oldest slot does not retire until it has received both a completion and a resolved predicate. With the buffer empty, `wb_valid` and `exc_valid` stay 0.
- R4: Slots retire strictly in allocation order, whatever the completion order, at most one per cycle. `wb_valid` and `exc_valid` are never both 1.
- R5: An oldest slot with predicate 1 and fault 0 raises `wb_valid` for one cycle. `wb_dest` carries the destination given at allocation and `wb_data` the completion result.
- R6: A completion with `cmp_fault`=1 only records the fault. No exception is signalled while the slot is younger than the oldest.
- R7: An oldest slot with predicate 1 and fault 1 raises `exc_valid` for one cycle with `exc_tag` equal to that slot's tag. `wb_valid` stays 0.
- R8: An oldest slot with predicate 0 retires with neither write nor exception, even when its fault is set. The next slot may retire in the following cycle.
- R9: In the exception cycle `alloc_ready` is 0. From the next cycle on the buffer is empty and the faulting tag is the next tag handed out. Completions addressed to flushed tags have no effect.
- R10: The predicate is taken from the completion when `cmp_pred_valid`=1. Otherwise it is taken from the resolve port (`prd_valid`, `prd_tag`, `prd_value`), which may come before or after the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A slot is free and no exception is being raised |
| alloc_dest | input | DEST_W | Destination register of the new operation |
| alloc_tag | output | TAG_W | Tag the next accepted allocation receives |
| cmp_valid | input | 1 | Completion report strobe |
| cmp_tag | input | TAG_W | Slot being completed |
| cmp_result | input | DATA_W | Computed result |
| cmp_fault | input | 1 | Execution detected a fault |
| cmp_pred | input | 1 | Predicate value carried by the completion |
| cmp_pred_valid | input | 1 | `cmp_pred` is meaningful |
| prd_valid | input | 1 | Stand-alone predicate resolve strobe |
| prd_tag | input | TAG_W | Slot whose predicate is resolved |
| prd_value | input | 1 | Resolved predicate value |
| wb_valid | output | 1 | Register write of the retiring slot |
| wb_dest | output | DEST_W | Register written |
| wb_data | output | DATA_W | Value written |
| exc_valid | output | 1 | Precise exception raised by the retiring slot |
| exc_tag | output | TAG_W | Tag of the faulting slot |

## Verification
The bench sweeps every combination of predicate and fault across four slots. Predicates reach some slots through the completion and others earlier through the resolve port, and completions arrive in reverse order.

- A design that raised faults at completion time would signal an exception while the faulting slot was still young.
- A design that ignored the predicate when deciding would trap on a dropped slot.
- A design that failed to clear younger slots, or that moved the tail anywhere but back to the head, would give the next allocation the wrong tag or retire flushed work.

Further directed runs cover the rest:

- **Full buffer:** all sixteen slots are filled. A design that wrapped wrongly would accept a seventeenth allocation or misorder the drain.
- **Held predicate:** a completed head waits for its predicate. A design that retired early would write before the predicate is known.
- **Stale completion:** a completion is sent to a flushed tag. A design that accepted it would later retire a slot that was never completed.

// File: rtl/dfrob_pkg.sv
package dfrob_pkg;

  // Per-slot status bits
  typedef struct packed {
    logic live;    // slot holds an operation
    logic done;    // completion received
    logic fault;   // execution fault noted, not yet reported
    logic pknown;  // predicate resolved
    logic pval;    // resolved predicate value
  } slot_flags_t;

  typedef enum logic [1:0] {
    RET_IDLE,
    RET_COMMIT,
    RET_TRAP,
    RET_DROP
  } ret_kind_e;

endpackage

// File: rtl/dfrob_ptr.sv
module dfrob_ptr #(
  parameter int DEPTH = 16,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [OCC_W-1:0] occ,
  output logic             full
);

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + TAG_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (flush) begin
      // faulting slot and all younger ones vanish; head stays put
      tail <= head;
      occ  <= '0;
    end else begin
      if (alloc_fire) tail <= bump(tail);
      if (retire)     head <= bump(head);
      case ({alloc_fire, retire})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign full = (occ == OCC_W'(DEPTH));

endmodule

// File: rtl/dfrob_store.sv
module dfrob_store
  import dfrob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_result,
  input  logic              cmp_fault,
  input  logic              cmp_pred,
  input  logic              cmp_pred_valid,
  input  logic              prd_valid,
  input  logic [TAG_W-1:0]  prd_tag,
  input  logic              prd_value,
  input  logic [TAG_W-1:0]  head,
  input  logic              retire,
  input  logic              flush,
  output slot_flags_t       head_flags,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_data
);

  slot_flags_t       flags  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];

  logic [DEPTH-1:0] a_hit, c_hit, p_hit, r_hit;

  // per-slot address decode
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign a_hit[i] = alloc_fire && (alloc_idx == TAG_W'(i));
    assign c_hit[i] = cmp_valid && (cmp_tag == TAG_W'(i)) && flags[i].live;
    assign p_hit[i] = prd_valid && (prd_tag == TAG_W'(i)) && flags[i].live;
    assign r_hit[i] = retire && (head == TAG_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush) begin
          flags[i] <= '0;
        end else if (a_hit[i]) begin
          flags[i] <= slot_flags_t'{live: 1'b1, default: 1'b0};
        end else if (r_hit[i]) begin
          flags[i] <= '0;
        end else begin
          if (p_hit[i]) begin
            flags[i].pknown <= 1'b1;
            flags[i].pval   <= prd_value;
          end
          if (c_hit[i]) begin
            flags[i].done  <= 1'b1;
            flags[i].fault <= cmp_fault;
            if (cmp_pred_valid) begin
              flags[i].pknown <= 1'b1;
              flags[i].pval   <= cmp_pred;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (c_hit[i]) data_q[i] <= cmp_result;
      if (a_hit[i]) dest_q[i] <= alloc_dest;
    end
  end

  assign head_flags = flags[head];
  assign head_dest  = dest_q[head];
  assign head_data  = data_q[head];

endmodule

// File: rtl/dfrob_retire.sv
module dfrob_retire
  import dfrob_pkg::*;
(
  input  slot_flags_t head_flags,
  output ret_kind_e   kind,
  output logic        retire,
  output logic        flush
);

  always_comb begin
    kind = RET_IDLE;
    if (head_flags.live && head_flags.done && head_flags.pknown) begin
      if (!head_flags.pval)     kind = RET_DROP;
      else if (head_flags.fault) kind = RET_TRAP;
      else                       kind = RET_COMMIT;
    end
  end

  assign retire = (kind != RET_IDLE);
  assign flush  = (kind == RET_TRAP);

endmodule

// File: rtl/deferred_fault_rob.sv
module deferred_fault_rob
  import dfrob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_result,
  input  logic              cmp_fault,
  input  logic              cmp_pred,
  input  logic              cmp_pred_valid,
  input  logic              prd_valid,
  input  logic [TAG_W-1:0]  prd_tag,
  input  logic              prd_value,
  output logic              wb_valid,
  output logic [DEST_W-1:0] wb_dest,
  output logic [DATA_W-1:0] wb_data,
  output logic              exc_valid,
  output logic [TAG_W-1:0]  exc_tag
);

  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head, tail;
  logic [OCC_W-1:0] occ;
  logic             full;
  logic             alloc_fire, retire, flush;
  slot_flags_t      head_flags;
  ret_kind_e        kind;

  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  dfrob_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .retire     (retire),
    .flush      (flush),
    .head       (head),
    .tail       (tail),
    .occ        (occ),
    .full       (full)
  );

  dfrob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_fire     (alloc_fire),
    .alloc_idx      (tail),
    .alloc_dest     (alloc_dest),
    .cmp_valid      (cmp_valid),
    .cmp_tag        (cmp_tag),
    .cmp_result     (cmp_result),
    .cmp_fault      (cmp_fault),
    .cmp_pred       (cmp_pred),
    .cmp_pred_valid (cmp_pred_valid),
    .prd_valid      (prd_valid),
    .prd_tag        (prd_tag),
    .prd_value      (prd_value),
    .head           (head),
    .retire         (retire),
    .flush          (flush),
    .head_flags     (head_flags),
    .head_dest      (wb_dest),
    .head_data      (wb_data)
  );

  dfrob_retire u_retire (
    .head_flags (head_flags),
    .kind       (kind),
    .retire     (retire),
    .flush      (flush)
  );

  assign wb_valid  = (kind == RET_COMMIT);
  assign exc_valid = (kind == RET_TRAP);
  assign exc_tag   = head;

endmodule

// File: rtl/dfrob_chk.sv
module dfrob_chk #(
  parameter int DEPTH = 16,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             wb_valid,
  input logic             exc_valid,
  input logic [OCC_W-1:0] occ
);

  // R4
  one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && exc_valid));

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> !alloc_ready);

  // R3
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !(wb_valid || exc_valid));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (occ == '0));

  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !alloc_ready);

  // R1
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=>
      (alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + TAG_W'(1))));

  // R5
  occ_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(alloc_valid && alloc_ready)) |=> (occ == $past(occ) - OCC_W'(1)));

endmodule

bind deferred_fault_rob dfrob_chk #(.DEPTH(DEPTH)) u_dfrob_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_tag   (alloc_tag),
  .wb_valid    (wb_valid),
  .exc_valid   (exc_valid),
  .occ         (occ)
);

// File: tb/deferred_fault_rob_bench.sv
`timescale 1ns/1ps
module deferred_fault_rob_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [4:0]  alloc_dest = '0;
  logic [3:0]  alloc_tag;
  logic        cmp_valid = 1'b0;
  logic [3:0]  cmp_tag = '0;
  logic [31:0] cmp_result = '0;
  logic        cmp_fault = 1'b0;
  logic        cmp_pred = 1'b0;
  logic        cmp_pred_valid = 1'b0;
  logic        prd_valid = 1'b0;
  logic [3:0]  prd_tag = '0;
  logic        prd_value = 1'b0;
  logic        wb_valid;
  logic [4:0]  wb_dest;
  logic [31:0] wb_data;
  logic        exc_valid;
  logic [3:0]  exc_tag;

  int         n_tests = 0;
  int         n_fail  = 0;
  bit         finished = 1'b0;
  logic [3:0] tail_m = '0;

  always #2.5 clk = ~clk;

  deferred_fault_rob u_deferred_fault_rob (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    alloc_valid = 1'b0; cmp_valid = 1'b0; prd_valid = 1'b0; cmp_pred_valid = 1'b0;
  endtask

  task automatic step_idle();
    @(negedge clk); clr(); #1;
  endtask

  task automatic no_retire(input string req);
    chk(!wb_valid && !exc_valid, req, 64'({wb_valid, exc_valid}), 64'(0));
  endtask

  task automatic alloc(input logic [4:0] d, output logic [3:0] t);
    @(negedge clk); clr();
    alloc_valid = 1'b1; alloc_dest = d; #1;
    chk(alloc_ready, "R2 ready while not full", 64'(alloc_ready), 64'(1));
    chk(alloc_tag == tail_m, "R1 allocation tag", 64'(alloc_tag), 64'(tail_m));
    t = alloc_tag;
    tail_m = tail_m + 4'd1;
  endtask

  task automatic complete(input logic [3:0] t, input logic [31:0] r, input logic f,
                          input logic p, input logic pv);
    @(negedge clk); clr();
    cmp_valid = 1'b1; cmp_tag = t; cmp_result = r; cmp_fault = f;
    cmp_pred = p; cmp_pred_valid = pv; #1;
  endtask

  task automatic resolve(input logic [3:0] t, input logic v);
    @(negedge clk); clr();
    prd_valid = 1'b1; prd_tag = t; prd_value = v; #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R4 watchdog expired actual=hung expected=drained");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] t0, t1, t2, n1, n2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step_idle();
    // R1 reset state
    chk(alloc_ready, "R1 reset ready", 64'(alloc_ready), 64'(1));
    chk(alloc_tag == 4'd0, "R1 reset tag", 64'(alloc_tag), 64'(0));
    no_retire("R1 reset outputs quiet");
    step_idle();
    no_retire("R3 empty buffer retires nothing");

    // R3 / R10: completed head waits for a late predicate
    alloc(5'd7, t0);
    complete(t0, 32'h77, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step_idle();
      no_retire("R3 head waits for predicate");
    end
    resolve(t0, 1'b1);
    no_retire("R3 predicate not yet latched");
    step_idle();
    chk(wb_valid && wb_data == 32'h77 && wb_dest == 5'd7, "R10 late predicate commit",
        64'(wb_data), 64'h77);
    step_idle();
    no_retire("R4 single retirement");

    // Sweep: every predicate/fault combination over four slots
    for (int pat = 0; pat < 256; pat++) begin
      logic [3:0] tg [4];
      bit stop;
      for (int j = 0; j < 4; j++) begin
        alloc(5'(pat + j), tg[j]);
        no_retire("R3 nothing completed");
      end
      resolve(tg[1], pat[2]);
      no_retire("R10 early predicate only");
      resolve(tg[3], pat[6]);
      no_retire("R10 early predicate only");
      for (int j = 3; j >= 0; j--) begin
        complete(tg[j], 32'hA500_0000 ^ 32'(pat << 4) ^ 32'(j), pat[2*j+1], pat[2*j], (j % 2) == 0);
        no_retire("R6 fault not raised at completion");
      end
      stop = 1'b0;
      for (int j = 0; j < 4; j++) begin
        if (!stop) begin
          step_idle();
          if (pat[2*j] && !pat[2*j+1]) begin
            chk(wb_valid && !exc_valid, "R5 commit", 64'({wb_valid, exc_valid}), 64'h2);
            chk(wb_dest == 5'(pat + j), "R5 dest", 64'(wb_dest), 64'(5'(pat + j)));
            chk(wb_data == (32'hA500_0000 ^ 32'(pat << 4) ^ 32'(j)), "R4 order/data",
                64'(wb_data), 64'(32'hA500_0000 ^ 32'(pat << 4) ^ 32'(j)));
          end else if (pat[2*j]) begin
            chk(exc_valid && !wb_valid, "R7 precise exception", 64'({wb_valid, exc_valid}), 64'h1);
            chk(exc_tag == tg[j], "R7 exception tag", 64'(exc_tag), 64'(tg[j]));
            chk(!alloc_ready, "R9 alloc blocked in exception cycle", 64'(alloc_ready), 64'(0));
            tail_m = tg[j];
            stop = 1'b1;
          end else begin
            no_retire("R8 false predicate discards silently");
          end
        end
      end
      step_idle();
      no_retire("R9 younger slots flushed or drained");
      chk(alloc_ready, "R9 ready after retire", 64'(alloc_ready), 64'(1));
      chk(alloc_tag == tail_m, "R9 next tag after flush", 64'(alloc_tag), 64'(tail_m));
    end

    // R2 / R4: fill every slot, then drain in order
    begin
      logic [3:0] ft [16];
      for (int k = 0; k < 16; k++) alloc(5'(k), ft[k]);
      @(negedge clk); clr(); alloc_valid = 1'b1; alloc_dest = 5'd31; #1;
      chk(!alloc_ready, "R2 full blocks allocation", 64'(alloc_ready), 64'(0));
      chk(alloc_tag == tail_m, "R2 tag holds when full", 64'(alloc_tag), 64'(tail_m));
      for (int k = 15; k >= 0; k--) begin
        complete(ft[k], 32'h1000 + 32'(k), 1'b0, 1'b1, 1'b1);
        no_retire("R4 head not complete yet");
      end
      for (int k = 0; k < 16; k++) begin
        step_idle();
        chk(wb_valid && wb_dest == 5'(k) && wb_data == 32'h1000 + 32'(k), "R4 in-order drain",
            64'(wb_data), 64'(32'h1000 + 32'(k)));
      end
      step_idle();
      no_retire("R2 blocked request left no slot");
    end

    // R9: completion addressed to a flushed tag is ignored
    alloc(5'd1, t0);
    alloc(5'd2, t1);
    alloc(5'd3, t2);
    complete(t1, 32'h11, 1'b0, 1'b1, 1'b1);
    complete(t2, 32'h22, 1'b0, 1'b1, 1'b1);
    complete(t0, 32'h00, 1'b1, 1'b1, 1'b1);
    step_idle();
    chk(exc_valid && exc_tag == t0, "R7 trap at head", 64'(exc_tag), 64'(t0));
    tail_m = t0;
    step_idle();
    no_retire("R9 flushed buffer idle");
    complete(t1, 32'hBAD, 1'b0, 1'b1, 1'b1);
    no_retire("R9 stale completion");
    step_idle();
    no_retire("R9 stale completion ignored");
    alloc(5'd9, n1);
    alloc(5'd10, n2);
    step_idle();
    no_retire("R9 reused tags start clean");
    complete(n2, 32'h2222, 1'b0, 1'b1, 1'b1);
    complete(n1, 32'h1111, 1'b0, 1'b1, 1'b1);
    step_idle();
    chk(wb_valid && wb_dest == 5'd9 && wb_data == 32'h1111, "R5 reused slot commit",
        64'(wb_data), 64'h1111);
    step_idle();
    chk(wb_valid && wb_dest == 5'd10 && wb_data == 32'h2222, "R5 reused slot commit",
        64'(wb_data), 64'h2222);
    step_idle();
    no_retire("R3 empty after drain");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule